// File: doc/BRIEF.md
# Addressable Bit Latch with Decoder Mode

This block stores eight independent bits behind a single data input. A 3-bit address picks one of them. Two active-low controls select what happens on each clock. A strobe lets the addressed bit track the data input, and the bit keeps the last value when the strobe is released. A wipe clears every bit. When the wipe and the strobe are both active, the block drives exactly one output with the data value and holds all the others at zero, so it works as a 1-of-8 decoder.

All inputs are sampled on the rising edge of the system clock, so the block is a synchronous stand-in for a transparent latch array. The release of the strobe is found by comparing the current strobe sample with the one from the previous clock. Callers should keep the address steady while the strobe is active.

Top module: `addr_latch`

## Requirements
- R1: A synchronous active-high reset sets all outputs to 0. It also records the previous strobe sample as inactive (high), so the first cycle after reset with strobe and wipe both high commits nothing.
- R2: With strobe_n low and wipe_n high, output bit q_out[addr] takes the value of data_in one clock later. Output bit i corresponds to address value i.
- R3: With strobe_n low and wipe_n high, every output bit other than q_out[addr] keeps its value.
- R4: With strobe_n high and wipe_n high, and strobe_n also high in the previous cycle, all outputs keep their values whatever data_in and addr do.
- R5: In the first cycle that strobe_n is sampled high after being sampled low, with wipe_n high, q_out[addr] takes the data_in value sampled in that cycle. All other bits hold.
- R6: With strobe_n high and wipe_n low, all eight outputs are 0 one clock later.
- R7: With strobe_n low and wipe_n low, one clock later q_out[addr] equals data_in and every other bit is 0.
- R8: When wipe_n returns high while strobe_n stays low, the block goes back to addressed writing. The other bits stay 0 and the addressed bit keeps tracking data_in.
- R9: When wipe_n is low in the same cycle that the strobe is released, the wipe wins: all outputs become 0 and no write is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Serial data bit to store |
| addr | input | 3 | Index of the selected output bit |
| strobe_n | input | 1 | Active-low write strobe; its release commits the data |
| wipe_n | input | 1 | Active-low clear |
| q_out | output | 8 | Stored bits; bit i belongs to address i |

## Verification
Every output bit is a register with no buffering after it. So a wrong stored bit, a missed commit or a bad mode decode shows up at q_out one clock after the input pattern that causes it. The bench compares all eight bits against its model on every clock. A fault in the previous-strobe register is different: it only shows at a strobe release, or on the first cycle after reset. The stimulus therefore releases the strobe many times, with the data, the address and the wipe state varied around each release.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_WRITE = 2'd1,
        MODE_CLEAR = 2'd2,
        MODE_DEMUX = 2'd3
    } latch_mode_e;

    typedef struct packed {
        logic data;
        logic strobe_n;
        logic wipe_n;
    } latch_ctrl_s;

    function automatic latch_mode_e mode_of(input latch_ctrl_s c);
        latch_mode_e m;
        if (!c.wipe_n) begin
            m = c.strobe_n ? MODE_CLEAR : MODE_DEMUX;
        end else begin
            m = c.strobe_n ? MODE_HOLD : MODE_WRITE;
        end
        return m;
    endfunction

endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
    import addr_latch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  latch_ctrl_s ctrl,
    output latch_mode_e mode,
    output logic        commit
);
    logic strobe_prev_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_prev_n <= 1'b1;
        end else begin
            strobe_prev_n <= ctrl.strobe_n;
        end
    end

    always_comb begin
        mode   = mode_of(ctrl);
        commit = (mode == MODE_HOLD) && !strobe_prev_n;
    end
endmodule

// File: rtl/addr_latch_dec.sv
module addr_latch_dec #(
    parameter int NUM_OUT = 8,
    localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_OUT-1:0] sel
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_dec
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/addr_latch_cell.sv
module addr_latch_cell
    import addr_latch_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel,
    input  logic        data,
    input  latch_mode_e mode,
    input  logic        commit,
    output logic        q
);
    logic q_next;

    always_comb begin
        q_next = q;
        unique case (mode)
            MODE_CLEAR: q_next = 1'b0;
            MODE_DEMUX: q_next = sel & data;
            MODE_WRITE: if (sel) q_next = data;
            MODE_HOLD:  if (sel && commit) q_next = data;
            default:    q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= q_next;
        end
    end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
    import addr_latch_pkg::*;
#(
    parameter int NUM_OUT = 8,
    localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               data_in,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               strobe_n,
    input  logic               wipe_n,
    output logic [NUM_OUT-1:0] q_out
);
    latch_ctrl_s          ctrl;
    latch_mode_e          mode;
    logic                 commit;
    logic [NUM_OUT-1:0]   sel;

    assign ctrl = '{data: data_in, strobe_n: strobe_n, wipe_n: wipe_n};

    addr_latch_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (ctrl),
        .mode   (mode),
        .commit (commit)
    );

    addr_latch_dec #(.NUM_OUT(NUM_OUT)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
        addr_latch_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .sel    (sel[i]),
            .data   (ctrl.data),
            .mode   (mode),
            .commit (commit),
            .q      (q_out[i])
        );
    end
endmodule

// File: rtl/addr_latch_chk.sv
module addr_latch_chk #(
    parameter int NUM_OUT = 8,
    localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               data_in,
    input logic [ADDR_W-1:0]  addr,
    input logic               strobe_n,
    input logic               wipe_n,
    input logic [NUM_OUT-1:0] q_out
);
    logic prev_n;
    always_ff @(posedge clk) begin
        if (rst) prev_n <= 1'b1;
        else     prev_n <= strobe_n;
    end

    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> (q_out == '0));

    p_track_r2: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && wipe_n) |=> (q_out[$past(addr)] == $past(data_in)));

    p_others_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && wipe_n) |=>
        (((q_out ^ $past(q_out)) & ~(NUM_OUT'(1) << $past(addr))) == '0));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe_n && wipe_n && prev_n) |=> $stable(q_out));

    p_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe_n && wipe_n && !prev_n) |=> (q_out[$past(addr)] == $past(data_in)));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (strobe_n && !wipe_n) |=> (q_out == '0));

    p_demux_r7: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !wipe_n) |=>
        (q_out == (NUM_OUT'($past(data_in)) << $past(addr))));

    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !wipe_n) |=> $onehot0(q_out));

    p_wipe_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (strobe_n && !wipe_n && !prev_n) |=> (q_out == '0));
endmodule

bind addr_latch addr_latch_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .addr     (addr),
    .strobe_n (strobe_n),
    .wipe_n   (wipe_n),
    .q_out    (q_out)
);

// File: tb/addr_latch_bench.sv
module addr_latch_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       data_in = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       strobe_n = 1'b1;
    logic       wipe_n = 1'b1;
    logic [7:0] q_out;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0] m_q = 8'h00;
    bit         m_prev = 1'b1;

    always #2 clk = ~clk;

    addr_latch u_addr_latch (
        .clk      (clk),
        .rst      (rst),
        .data_in  (data_in),
        .addr     (addr),
        .strobe_n (strobe_n),
        .wipe_n   (wipe_n),
        .q_out    (q_out)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    task automatic step(input bit r, input bit d, input int a, input bit s_n,
                        input bit w_n, input string tag);
        data_in  = d;
        addr     = 3'(a);
        strobe_n = s_n;
        wipe_n   = w_n;
        rst      = r;
        @(posedge clk);
        #1;
        if (r) begin
            m_q = 8'h00;
            m_prev = 1'b1;
        end else begin
            if (!w_n) begin
                m_q = 8'h00;
                if (!s_n) m_q[a] = d;
            end else if (!s_n) begin
                m_q[a] = d;
            end else if (!m_prev) begin
                m_q[a] = d;
            end
            m_prev = s_n;
        end
        vectors++;
        if (q_out !== m_q) begin
            miscompares++;
            $display("FAIL %s: q_out actual %b expected %b", tag, q_out, m_q);
        end
    endtask

    function automatic string tag_for(bit s_n, bit w_n, bit prev);
        if (!w_n) return s_n ? (prev ? "R6" : "R9") : "R7";
        if (!s_n) return "R2 R3";
        return prev ? "R4" : "R5";
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R1: reset state, then no commit right after reset
        step(1, 1, 5, 0, 1, "R1");
        step(1, 1, 5, 0, 1, "R1");
        step(0, 1, 5, 1, 1, "R1");
        // R4: hold ignores data and address
        step(0, 1, 2, 1, 1, "R4");
        step(0, 0, 7, 1, 1, "R4");
        // R2 R3: address 3 tracks data
        step(0, 1, 3, 0, 1, "R2");
        step(0, 0, 3, 0, 1, "R2");
        step(0, 1, 3, 0, 1, "R3");
        // R5: release commits data sampled at release
        step(0, 1, 3, 1, 1, "R5");
        step(0, 0, 3, 1, 1, "R4");
        // release with data dropped to 0 at the release cycle
        step(0, 1, 6, 0, 1, "R2");
        step(0, 0, 6, 1, 1, "R5");
        step(0, 1, 0, 0, 1, "R3");
        step(0, 1, 0, 1, 1, "R5");
        // R6: clear all
        step(0, 1, 4, 1, 0, "R6");
        step(0, 1, 4, 1, 1, "R4");
        // R7: decoder sweep
        for (int i = 0; i < 8; i++) step(0, 1, i, 0, 0, "R7");
        step(0, 0, 2, 0, 0, "R7");
        // R8: wipe released while strobe low
        step(0, 1, 5, 0, 0, "R7");
        step(0, 0, 5, 0, 1, "R8");
        step(0, 1, 5, 0, 1, "R8");
        step(0, 1, 5, 1, 1, "R5");
        // R9: wipe together with strobe release
        step(0, 1, 1, 0, 1, "R2");
        step(0, 1, 1, 1, 0, "R9");
        step(0, 1, 1, 1, 1, "R9");
        // mixed pattern driven by the model
        for (int k = 0; k < 600; k++) begin
            bit d = 1'($urandom);
            int a = int'($urandom_range(7, 0));
            bit s = ($urandom_range(2, 0) != 0);
            bit w = ($urandom_range(5, 0) != 0);
            bit r = ($urandom_range(99, 0) == 0);
            step(r, d, a, s, w, r ? "R1" : tag_for(s, w, m_prev));
        end
        report();
    end
endmodule